// File: doc/BRIEF.md
# Software Watchdog Timer

This block is a watchdog that software must service at regular intervals. A free-running prescaler that software cannot see divides the clock by 256. Each full prescaler cycle advances a 16-bit up-counter, and the counter is compared against a limit held in a reference register. Once the counter reaches the limit while the watchdog is enabled, the block issues a one-clock timeout pulse and sets a sticky timeout flag. A system reset controller outside this block acts on these outputs. Software keeps the watchdog from expiring by writing to the counter location. Any such write clears the counter and the prescaler, whatever data it carries.

The block has two word registers on a small synchronous register bus. The reference register is at offset 0. It holds a 15-bit limit in bits 15..1 and the enable bit in bit 0. The counter is at offset 1: a read returns the live count and a write services the watchdog. After reset the watchdog is enabled and set to its longest timeout.

A small state machine controls the timeout output. It has three states. ST_IDLE means the watchdog is disabled. ST_ARMED means it is counting and may fire. ST_EXPIRED means it has fired and waits to be serviced. The transitions are:
- T_ENABLE: from ST_IDLE to ST_ARMED when the enable bit is 1.
- T_EXPIRE: from ST_ARMED to ST_EXPIRED on a limit match with no counter write in the same clock. This transition fires the pulse.
- T_REARM: from ST_EXPIRED to ST_ARMED on a counter write.
- T_DISABLE: from any state to ST_IDLE when the enable bit is 0. This transition has the highest priority.

Top module: `wdog_timer`

## Requirements
- R1: After reset the reference register reads 0xFFFF, the counter reads 0, and timeout_pulse and timeout_flag are 0.
- R2: While enabled, the counter advances by exactly one every 256 clocks. Counting is measured from the most recent counter write.
- R3: The limit comparison uses counter bits 15..1 against reference bits 15..1 and ignores counter bit 0. With limit field L (reference = {L, 1}), the timeout fires when the count first becomes 2L. timeout_pulse is high in the clock following the edge after that count is reached.
- R4: While reference bit 0 is 0, the counter is held at 0, it does not count, and no timeout pulse is issued.
- R5: A write to offset 1 clears both the counter and the prescaler, whatever the write data.
- R6: A read of offset 1 returns the live count and does not change counting or prescaling, even if the read strobe is held.
- R7: The reference register at offset 0 can be written and read back at any time.
- R8: timeout_pulse lasts one clock and fires once per arming. timeout_flag rises with the pulse and stays set until the next counter write or reset.
- R9: When a counter write and a prescaler tick fall in the same clock, the write wins and the counter reads 0 afterwards.
- R10: rdata is 0 when no read is selected, and reads of offsets 2 and 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Block select for a bus cycle |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Word offset: 0 = reference, 1 = counter |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational |
| timeout_pulse | output | 1 | One-clock timeout request |
| timeout_flag | output | 1 | Sticky timeout indication |

## Verification
The main function is tried with a set of limits: 0, which fires at once after service, then 1, 2, 3 and 5. Each limit checks the exact clock count from service to pulse, so it separates a comparison that includes bit 0 from one that ignores it. It also catches a prescaler that is not reset by service. Directed patterns place a service write midway through a prescaler cycle and exactly on a tick edge, which tells a prescaler clear apart from write-over-tick priority. Other patterns hold the read strobe during the countdown, keep the watchdog disabled past several limits, and idle after expiry, which shows that the pulse fires once and the flag is sticky.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_EXPIRED
    } wd_state_t;

    localparam int OFS_REF = 0;
    localparam int OFS_CNT = 1;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

    logic [PRE_W-1:0] pre_q;

    assign tick = run && (pre_q == PRE_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic kick,
    input  logic match,
    output logic pulse,
    output logic flag
);
    wd_state_t state_q, state_d;
    logic      fire;

    assign fire = (state_q == ST_ARMED) && en && match && !kick;

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_ARMED;
                ST_ARMED:   if (fire) state_d = ST_EXPIRED;
                ST_EXPIRED: if (kick) state_d = ST_ARMED;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
            flag  <= 1'b0;
        end else begin
            pulse <= fire;
            if (kick) begin
                flag <= 1'b0;
            end else if (fire) begin
                flag <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int PRE_W  = 8,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              timeout_pulse,
    output logic              timeout_flag
);
    localparam logic [ADDR_W-1:0] A_REF = ADDR_W'(OFS_REF);
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFS_CNT);

    logic [CNT_W-1:0] ref_q;
    logic [CNT_W-1:0] cnt_q;
    logic             en;
    logic             kick;
    logic             ref_wr;
    logic             tick;
    logic             match;

    assign en     = ref_q[0];
    assign ref_wr = sel && wr && (addr == A_REF);
    assign kick   = sel && wr && (addr == A_CNT);
    assign match  = (cnt_q[CNT_W-1:1] == ref_q[CNT_W-1:1]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '1;
        end else if (ref_wr) begin
            ref_q <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel && rd) begin
            if (addr == A_REF) begin
                rdata = ref_q;
            end else if (addr == A_CNT) begin
                rdata = cnt_q;
            end
        end
    end

    wdog_prescaler #(.PRE_W(PRE_W)) pre_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (en),
        .clr   (kick),
        .tick  (tick)
    );

    wdog_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (en),
        .clr   (kick),
        .tick  (tick),
        .cnt   (cnt_q)
    );

    wdog_fsm fsm_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .kick  (kick),
        .match (match),
        .pulse (timeout_pulse),
        .flag  (timeout_flag)
    );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              rd,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [CNT_W-1:0]  rdata,
    input logic [CNT_W-1:0]  ref_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              timeout_pulse,
    input logic              timeout_flag
);
    logic cnt_write;
    assign cnt_write = sel && wr && (addr == ADDR_W'(1));

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |=> !timeout_pulse);

    assert_flag_with_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> timeout_flag);

    assert_hold_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_q[0] |=> (cnt_q == '0) && !timeout_pulse);

    assert_write_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_write |=> (cnt_q == '0) && !timeout_flag);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0)));

    assert_pulse_on_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> $past(cnt_q[CNT_W-1:1] == ref_q[CNT_W-1:1]));

    assert_idle_bus_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(sel && rd) || (addr > ADDR_W'(1))) |-> (rdata == '0));
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel           (sel),
    .rd            (rd),
    .wr            (wr),
    .addr          (addr),
    .rdata         (rdata),
    .ref_q         (ref_q),
    .cnt_q         (cnt_q),
    .timeout_pulse (timeout_pulse),
    .timeout_flag  (timeout_flag)
);

// File: tb/wdog_timer_tb_top.sv
`timescale 1ns/1ps
module wdog_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        timeout_pulse;
    logic        timeout_flag;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    wdog_timer dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .sel           (sel),
        .rd            (rd),
        .wr            (wr),
        .addr          (addr),
        .wdata         (wdata),
        .rdata         (rdata),
        .timeout_pulse (timeout_pulse),
        .timeout_flag  (timeout_flag)
    );

    // {limit field L, clocks from service write to pulse = 256*2L + 2}
    localparam logic [31:0] VEC [5] = '{
        {16'd0, 16'd2},
        {16'd1, 16'd514},
        {16'd2, 16'd1026},
        {16'd3, 16'd1538},
        {16'd5, 16'd2562}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = 16'd0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
        sel = 1'b1; rd = 1'b1; addr = a;
        #0.5;
        d = rdata;
        sel = 1'b0; rd = 1'b0;
    endtask

    task automatic wait_pulse(output int n);
        n = 1;
        while (!timeout_pulse && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int          n;
        int          pulses;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_rd(2'd0, d); check(d == 16'hFFFF, "R1 ref reset", d, 16'hFFFF);
        bus_rd(2'd1, d); check(d == 16'h0000, "R1 cnt reset", d, 0);
        check(!timeout_pulse && !timeout_flag, "R1 outputs reset",
              {timeout_pulse, timeout_flag}, 0);
        // R10 other offsets and idle bus
        bus_rd(2'd2, d); check(d == 16'h0, "R10 offset 2", d, 0);
        bus_rd(2'd3, d); check(d == 16'h0, "R10 offset 3", d, 0);
        #0.5; check(rdata == 16'h0, "R10 no strobe", rdata, 0);
        @(negedge clk);

        // R3 / R2 limit vectors
        foreach (VEC[i]) begin
            logic [15:0] lim;
            lim = VEC[i][31:16];
            bus_wr(2'd0, {lim[14:0], 1'b1});
            repeat (37) @(negedge clk);
            bus_wr(2'd1, 16'h0000);
            wait_pulse(n);
            check(n == int'(VEC[i][15:0]), "R3 pulse timing", n, int'(VEC[i][15:0]));
            bus_rd(2'd1, d);
            check(d == 16'(2 * lim), "R3 count at pulse", d, 2 * lim);
            @(negedge clk);
        end

        // R8 single pulse and sticky flag
        pulses = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (timeout_pulse) pulses++;
        end
        check(pulses == 0, "R8 single pulse", pulses, 0);
        check(timeout_flag == 1'b1, "R8 flag sticky", timeout_flag, 1);
        bus_wr(2'd1, 16'hFFFF);
        check(timeout_flag == 1'b0, "R8 flag cleared by write", timeout_flag, 0);
        // R5 data ignored
        bus_rd(2'd1, d); check(d == 16'h0, "R5 write data ignored", d, 0);

        // R6 read strobe held during countdown, limit 2
        bus_wr(2'd0, 16'h0005);
        bus_wr(2'd1, 16'h0000);
        sel = 1'b1; rd = 1'b1; addr = 2'd1;
        wait_pulse(n);
        d = rdata;
        sel = 1'b0; rd = 1'b0;
        check(n == 1026, "R6 held read timing", n, 1026);
        check(d == 16'd4, "R6 live count", d, 4);

        // R2 rate, 16-bit limit maximal
        bus_wr(2'd0, 16'hFFFF);
        bus_wr(2'd1, 16'h0000);
        repeat (599) @(negedge clk);
        bus_rd(2'd1, d); check(d == 16'd2, "R2 count after 600 clocks", d, 2);

        // R5 prescaler cleared mid-cycle
        bus_wr(2'd1, 16'h0000);
        repeat (100) @(negedge clk);
        bus_wr(2'd1, 16'h1234);
        repeat (255) @(negedge clk);
        bus_rd(2'd1, d); check(d == 16'd0, "R5 prescaler cleared", d, 0);
        @(negedge clk);
        bus_rd(2'd1, d); check(d == 16'd1, "R5 first tick after clear", d, 1);

        // R9 write on the tick edge
        bus_wr(2'd1, 16'h0000);
        repeat (255) @(negedge clk);
        bus_wr(2'd1, 16'h0000);
        bus_rd(2'd1, d); check(d == 16'd0, "R9 write beats tick", d, 0);
        repeat (256) @(negedge clk);
        bus_rd(2'd1, d); check(d == 16'd1, "R9 count resumes", d, 1);

        // R7 reference read-back (enable bit 0 disables)
        bus_wr(2'd0, 16'h1234);
        bus_rd(2'd0, d); check(d == 16'h1234, "R7 ref readback", d, 16'h1234);

        // R4 disabled: no count, no pulse
        bus_wr(2'd1, 16'h0000);
        pulses = 0;
        for (int k = 0; k < 1500; k++) begin
            @(negedge clk);
            if (timeout_pulse) pulses++;
        end
        bus_rd(2'd1, d); check(d == 16'd0, "R4 counter held", d, 0);
        check(pulses == 0, "R4 no pulse", pulses, 0);
        bus_wr(2'd0, 16'h0000);
        pulses = 0;
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            if (timeout_pulse) pulses++;
        end
        check(pulses == 0, "R4 zero limit disabled", pulses, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule